// File: doc/BRIEF.md
# Banked Register Address Decoder

This block sits behind the register-access path of a sensor serial interface. It takes a 7-bit register address with a read or write strobe and steers the access to one of several targets. The targets are internal configuration RAM, a byte of the external configuration memory, the read-only status registers, the write-only command register, or a local interface-parameter register that the block holds itself. A 3-bit memory configuration code selects how the address is interpreted. With code zero, the address is used directly against a 128-byte memory. With any other code, the lower half of the address space becomes a 64-byte window into a bank chosen by a bank-select value, and the upper half stays fixed.

Every strobed access produces a registered decision one clock later. That decision is the target select, the 11-bit physical external-memory address, the memory area the byte belongs to, and an error flag. An access flagged as an error selects no target. The external memory holds its configuration, data-sheet and user areas back to back in that order, and the area sizes follow the code table in R9. The block does not talk to the memory itself.

Top module: `bank_addr_dec`

## Requirements
- R1: While reset is asserted and in the cycle after it, tgt_sel is 0 (none), mem_addr is 0, mem_area is 0, acc_err is 0 and iface_par equals the PAR_INIT parameter (default 8'hA5).
- R2: With mem_cfg = 0, any read or write to an address in 0x00..0x4F other than 0x4C gives tgt_sel = 1 (internal RAM), with mem_addr = 0, whatever bank_sel holds.
- R3: With mem_cfg = 0, addresses 0x50..0x74, 0x78..0x7B and 0x7D..0x7F give tgt_sel = 2 (external) for reads and writes, with mem_addr equal to the address and mem_area = 0, whatever bank_sel holds.
- R4: In every mode, a read of 0x75, 0x76 or 0x77 gives tgt_sel = 3 (status). A write to 0x75 or 0x76 raises acc_err and selects nothing.
- R5: In every mode, a write to 0x77 gives tgt_sel = 4 (command).
- R6: In every mode, addresses 0x7C and 0x4C both give tgt_sel = 5 (parameter register). A write to either loads wr_data into iface_par, visible one cycle later. No other stimulus changes iface_par.
- R7: With mem_cfg not 0, an address in 0x00..0x3F gives tgt_sel = 2 with mem_addr = bank_sel*64 + (address mod 64).
- R8: With mem_cfg not 0, a dynamic-window access whose bank_sel is at or beyond the total bank count for the code raises acc_err, with tgt_sel = 0 and mem_addr = 0.
- R9: A valid dynamic access reports mem_area 0 (configuration), 1 (data sheet) or 2 (user). The area follows from bank_sel against the counts for the code: 1:(3,1,0) 2:(3,4,1) 3:(3,4,9) 4:(3,12,1) 5:(3,4,25) 6:(3,12,17) 7:(3,24,5).
- R10: With mem_cfg not 0, addresses 0x40..0x7F other than 0x4C and 0x75..0x77 and 0x7C give tgt_sel = 2, mem_addr equal to the address and mem_area = 0, even when bank_sel is out of range.
- R11: Without a strobe the outputs return to tgt_sel = 0, acc_err = 0. Read and write strobes together raise acc_err with no target and no parameter update.
- R12: All decisions appear on the outputs in the clock cycle after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 7 | Register-access address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| mem_cfg | input | 3 | Memory configuration code |
| bank_sel | input | 6 | Bank for the dynamic window |
| tgt_sel | output | 3 | Target: 0 none, 1 RAM, 2 external, 3 status, 4 command, 5 parameter |
| mem_addr | output | 11 | Physical external-memory address |
| mem_area | output | 2 | Area of an external byte: 0 conf, 1 data sheet, 2 user |
| acc_err | output | 1 | Access rejected |
| iface_par | output | 8 | Interface-parameter register contents |

## Verification
The hardest case combines three conditions: the configuration with the most data-sheet banks, bank_sel pushed past the last valid bank, and an access to the static window. The window must then ignore the bad bank while the dynamic window beside it rejects the access. The stimulus walks bank_sel across every code from 0 to 40, past every area boundary and the total count. For each code it also sweeps the whole static half with bank_sel at 63. Writes to the mirror address carry fresh data, so a change through the wrong alias shows up on iface_par.

// File: rtl/bank_addr_dec.sv
module bank_addr_dec #(
  parameter int AW = 7,
  parameter int BANK_W = 6,
  parameter int MW = 11,
  parameter logic [7:0] PAR_INIT = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     acc_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        mem_cfg,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [2:0]        tgt_sel,
  output logic [MW-1:0]     mem_addr,
  output logic [1:0]        mem_area,
  output logic              acc_err,
  output logic [7:0]        iface_par
);
  localparam logic [2:0] T_NONE = 3'd0, T_RAM = 3'd1, T_EXT = 3'd2,
                         T_STAT = 3'd3, T_CMD = 3'd4, T_PAR = 3'd5;
  localparam int CW = BANK_W + 1;
  localparam int DW = BANK_W + 6;

  logic [CW-1:0] n_conf, n_eds, n_user, n_tot, bank_x;
  logic [DW-1:0] dyn_phys;
  logic          direct, par_we, nx_err;
  logic [2:0]    nx_sel;
  logic [MW-1:0] nx_addr;
  logic [1:0]    nx_area;

  always_comb begin
    n_conf = CW'(3); n_eds = '0; n_user = '0;
    case (mem_cfg)
      3'd0: n_conf = CW'(2);
      3'd1: n_eds = CW'(1);
      3'd2: begin n_eds = CW'(4);  n_user = CW'(1);  end
      3'd3: begin n_eds = CW'(4);  n_user = CW'(9);  end
      3'd4: begin n_eds = CW'(12); n_user = CW'(1);  end
      3'd5: begin n_eds = CW'(4);  n_user = CW'(25); end
      3'd6: begin n_eds = CW'(12); n_user = CW'(17); end
      default: begin n_eds = CW'(24); n_user = CW'(5); end
    endcase
  end

  assign n_tot    = n_conf + n_eds + n_user;
  assign bank_x   = {1'b0, bank_sel};
  assign dyn_phys = {bank_sel, acc_addr[5:0]};
  assign direct   = (mem_cfg == 3'd0);

  always_comb begin
    nx_sel = T_NONE; nx_err = 1'b0; nx_addr = '0; nx_area = 2'd0; par_we = 1'b0;
    if (rd_stb && wr_stb) begin
      nx_err = 1'b1;
    end else if (rd_stb || wr_stb) begin
      if (acc_addr == 7'h7C || acc_addr == 7'h4C) begin
        nx_sel = T_PAR;
        par_we = wr_stb;
      end else if (acc_addr >= 7'h75 && acc_addr <= 7'h77) begin
        if (!wr_stb)               nx_sel = T_STAT;
        else if (acc_addr == 7'h77) nx_sel = T_CMD;
        else                        nx_err = 1'b1;
      end else if (direct && acc_addr < 7'h50) begin
        nx_sel = T_RAM;
      end else if (!direct && !acc_addr[6]) begin
        if (bank_x >= n_tot) begin
          nx_err = 1'b1;
        end else begin
          nx_sel  = T_EXT;
          nx_addr = dyn_phys[MW-1:0];
          if (bank_x < n_conf)              nx_area = 2'd0;
          else if (bank_x < n_conf + n_eds) nx_area = 2'd1;
          else                              nx_area = 2'd2;
        end
      end else begin
        nx_sel  = T_EXT;
        nx_addr = MW'(acc_addr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_sel   <= T_NONE;
      mem_addr  <= '0;
      mem_area  <= 2'd0;
      acc_err   <= 1'b0;
      iface_par <= PAR_INIT;
    end else begin
      tgt_sel  <= nx_sel;
      mem_addr <= nx_addr;
      mem_area <= nx_area;
      acc_err  <= nx_err;
      if (par_we) iface_par <= wr_data;
    end
  end

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (tgt_sel == T_NONE && mem_addr == '0));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> (tgt_sel == T_NONE && !acc_err));

  assert_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb) |=> (acc_err && $stable(iface_par)));

  assert_par_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && !rd_stb && (acc_addr == 7'h7C || acc_addr == 7'h4C)) |=> $stable(iface_par));

  assert_cmd_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && acc_addr == 7'h77) |=> (tgt_sel == T_CMD));

  assert_direct_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mem_cfg == 3'd0) |=> (mem_addr[MW-1:7] == '0));

  assert_stat_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && (acc_addr == 7'h75 || acc_addr == 7'h76)) |=> acc_err);
endmodule

// File: tb/sim_bank_addr_dec.sv
module sim_bank_addr_dec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] a_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] d_i = '0;
  logic [2:0] c_i = '0;
  logic [5:0] b_i = '0;
  logic [2:0] sel_o;
  logic [10:0] addr_o;
  logic [1:0] area_o;
  logic err_o;
  logic [7:0] par_o;

  int total = 0, bad = 0;
  int e_sel = 0, e_addr = 0, e_area = 0, e_err = 0, m_par = 8'hA5;
  string cur_tag = "R1";

  bank_addr_dec u0 (.clk(clk), .rst_n(rst_n), .acc_addr(a_i), .rd_stb(rd_i), .wr_stb(wr_i),
    .wr_data(d_i), .mem_cfg(c_i), .bank_sel(b_i), .tgt_sel(sel_o), .mem_addr(addr_o),
    .mem_area(area_o), .acc_err(err_o), .iface_par(par_o));

  always #2 clk = ~clk;

  function automatic int cnt(input int c, input int k);
    int t[8][3] = '{'{2,0,0}, '{3,1,0}, '{3,4,1}, '{3,4,9}, '{3,12,1}, '{3,4,25}, '{3,12,17}, '{3,24,5}};
    return t[c][k];
  endfunction

  task automatic compare();
    total++;
    if (int'(sel_o) != e_sel || int'(addr_o) != e_addr || int'(area_o) != e_area ||
        int'(err_o) != e_err || int'(par_o) != m_par) begin
      bad++;
      $display("FAIL %s: got sel=%0d addr=%0h area=%0d err=%0d par=%0h exp sel=%0d addr=%0h area=%0d err=%0d par=%0h",
        cur_tag, sel_o, addr_o, area_o, err_o, par_o, e_sel, e_addr, e_area, e_err, m_par);
    end
  endtask

  task automatic step(input int a, input bit r, input bit w, input int d, input int c, input int b);
    int tot;
    @(negedge clk);
    compare();
    a_i = 7'(a); rd_i = r; wr_i = w; d_i = 8'(d); c_i = 3'(c); b_i = 6'(b);
    tot = cnt(c,0) + cnt(c,1) + cnt(c,2);
    e_sel = 0; e_addr = 0; e_area = 0; e_err = 0;
    if (r && w) begin e_err = 1; cur_tag = "R11"; end
    else if (!r && !w) cur_tag = "R11";
    else if (a == 'h7C || a == 'h4C) begin e_sel = 5; if (w) m_par = d; cur_tag = "R6"; end
    else if (a >= 'h75 && a <= 'h77) begin
      if (!w) begin e_sel = 3; cur_tag = "R4"; end
      else if (a == 'h77) begin e_sel = 4; cur_tag = "R5"; end
      else begin e_err = 1; cur_tag = "R4"; end
    end
    else if (c == 0 && a < 'h50) begin e_sel = 1; cur_tag = "R2"; end
    else if (c == 0) begin e_sel = 2; e_addr = a; cur_tag = "R3"; end
    else if (a < 'h40) begin
      if (b >= tot) begin e_err = 1; cur_tag = "R8"; end
      else begin
        e_sel = 2; e_addr = b * 64 + a % 64;
        e_area = (b < cnt(c,0)) ? 0 : (b < cnt(c,0) + cnt(c,1)) ? 1 : 2;
        cur_tag = (b >= cnt(c,0)) ? "R9" : "R7";
      end
    end
    else begin e_sel = 2; e_addr = a; cur_tag = "R10"; end
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got hang exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();  // R1 during reset
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);  // R1 first cycle after reset (checked next step), R12 timing throughout
    for (int a = 0; a < 128; a++) step(a, 1, 0, 0, 0, (a * 7) % 64);
    for (int a = 0; a < 128; a++) step(a, 0, 1, a ^ 8'h3C, 0, a % 64);
    for (int c = 1; c < 8; c++) begin
      for (int b = 0; b <= 40; b++) begin
        step((b * 5 + c) % 64, 1, 0, 0, c, b);
        step((b * 11) % 64, 0, 1, b, c, b);
      end
      for (int a = 64; a < 128; a++) step(a, (a % 3) != 0, (a % 3) == 0, a + c, c, 63);
    end
    step('h7C, 1, 1, 8'h00, 2, 0);
    step('h4C, 1, 1, 8'hFF, 0, 0);
    step('h10, 1, 1, 0, 3, 70);
    step('h4C, 0, 1, 8'h99, 7, 63);
    step('h7C, 1, 0, 0, 7, 63);
    step(0, 0, 0, 0, 7, 0);
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule